// File: doc/BRIEF.md
# I2C Register Master with Host Mailboxes

This block lets a host processor perform single-byte register writes and reads on an I2C slave without handling the bus bit by bit. The host first loads an extension mailbox. Its low byte is the slave's register index, and for a write its high byte is the value to store. The host then writes one command word that holds the 7-bit slave address and a direction bit. That single write runs the whole transfer.

A shared status word reports three things:
- a busy flag while the transfer runs;
- a read-complete flag once fetched data is available;
- a sticky flag when the slave refused an address or register byte.

On a read, the fetched byte is returned in the upper half of the extension mailbox.

On the bus side, a bit engine times every bit from a system-clock divider. A control sequencer steps the engine through the slots of one transfer: start, address, register index, then either the data byte or a repeated start, address again and the data byte. Every transfer ends with a stop. SCL and SDA are modelled as open-drain levels, where 1 means released.

Top module: `i2c_mailbox_master`

## Requirements
- R1: After reset, status, read-back mailbox and both bus lines read as idle: status 0x0000, extension read-back 0x0000, sclOut and sdaOut 1.
- R2: A write to address 0 while status bit 12 is clear sets status bit 12 on the next cycle and starts a transfer. Command bits 7:1 give the slave address, and bit 10 selects write (1) or read (0).
- R3: While status bit 12 is set, writes to address 0 and address 1 are ignored: the running transfer completes with its original slave, register and data bytes.
- R4: A write transfer puts on the bus: start, (slave<<1|0), register byte from extension bits 7:0, data byte from extension bits 15:8, stop. Bytes go MSB first, and each is followed by a ninth clock with SDA released for the slave acknowledge.
- R5: A read transfer puts on the bus: start, (slave<<1|0), register byte, repeated start, (slave<<1|1), one data byte that the master NACKs by leaving SDA released, stop.
- R6: When a read ends without a NACK, the received byte appears in bits 15:8 of a read of address 1, with bits 7:0 zero. Status bit 14 sets in the same cycle that bit 12 clears.
- R7: Writing 1 to status bit 14 (address 2) clears it; writing 0 there leaves it unchanged.
- R8: A NACK on the address, register or write-data byte ends the transfer with a stop and sets status bit 13, which stays set until a 1 is written to bit 13. Bit 14 does not set on such a read.
- R9: SDA changes while SCL is high only inside a start or stop condition. Within a transfer the shortest SCL period is CLK_DIV system clocks.
- R10: Whenever status bit 12 is clear, both bus lines are released (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 2 | Host word address: 0 command, 1 extension mailbox, 2 status |
| hostWe | input | 1 | Host write strobe, one cycle per write |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Combinational read data for hostAddr |
| sclOut | output | 1 | SCL level, 1 = released |
| sdaOut | output | 1 | SDA level, 1 = released |
| sdaIn | input | 1 | Sensed SDA line level |

## Verification
The main function is exercised with a modelled slave under four kinds of stimulus:
- writes and reads to an acknowledging address, using register and data bytes at all-ones, all-zeros and alternating patterns, which separates bit-order and byte-slot mistakes;
- a read of an address nobody answers, which must stop right after the address byte;
- a read whose register byte is refused, which must stop before the repeated start;
- a command written while busy, which must leave the bus sequence unchanged.

Status flags, read-back data and the shortest SCL period are compared after each case.

// File: rtl/i2cmbx_pkg.sv
package i2cmbx_pkg;

  // host word addresses
  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_EXT  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

  // bit positions in command and status words
  localparam int CMD_WRITE_BIT  = 10;
  localparam int STAT_BUSY_BIT  = 12;
  localparam int STAT_NACK_BIT  = 13;
  localparam int STAT_RDONE_BIT = 14;

  typedef enum logic [1:0] {
    SLOT_START = 2'd0,
    SLOT_STOP  = 2'd1,
    SLOT_BYTE  = 2'd2
  } slotKind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic      go;
    slotKind_e kind;
    logic [7:0] txByte;
  } slotCmd_t;

  // datapath -> control
  typedef struct packed {
    logic       done;
    logic       ackBit;   // 1 = slave did not acknowledge
    logic [7:0] rxByte;
    logic       active;
  } slotRsp_t;

  typedef enum logic [3:0] {
    STP_IDLE, STP_START, STP_ADDRW, STP_REG, STP_DATA,
    STP_RSTART, STP_ADDRR, STP_RDATA, STP_STOP
  } step_e;

endpackage

// File: rtl/i2cmbx_bit_engine.sv
module i2cmbx_bit_engine
  import i2cmbx_pkg::*;
#(
  parameter int CLK_DIV = 400
) (
  input  logic      clk,
  input  logic      rstN,
  input  slotCmd_t  cmd,
  output slotRsp_t  rsp,
  output slotKind_e curKind,
  output logic      sclOut,
  output logic      sdaOut,
  input  logic      sdaIn
);

  localparam int QDIV = CLK_DIV / 4;
  localparam int DW   = (QDIV > 1) ? $clog2(QDIV) : 1;

  logic [DW-1:0] divCnt;
  logic [1:0]    qIdx;
  logic [3:0]    bitIdx;
  logic          active;
  slotKind_e     kind;
  logic [7:0]    shReg;
  logic          sampleBit;
  logic          sclReg, sdaReg;
  logic          doneReg, ackReg;
  logic          sclWant, sdaWant;
  logic          quarterEnd, slotEnd;

  assign quarterEnd = (divCnt == DW'(QDIV - 1));
  assign slotEnd    = active && quarterEnd && (qIdx == 2'd3) &&
                      ((kind != SLOT_BYTE) || (bitIdx == 4'd8));

  // SCL low in quarters 0,1 and high in 2,3; SDA holds in quarter 0
  always_comb begin
    sclWant = qIdx[1];
    sdaWant = sdaReg;
    if (qIdx != 2'd0) begin
      unique case (kind)
        SLOT_START: sdaWant = (qIdx != 2'd3);
        SLOT_STOP:  sdaWant = (qIdx == 2'd3);
        default:    sdaWant = (bitIdx == 4'd8) ? 1'b1 : shReg[7];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= '0;
      qIdx      <= 2'd0;
      bitIdx    <= 4'd0;
      active    <= 1'b0;
      kind      <= SLOT_STOP;
      shReg     <= 8'hFF;
      sampleBit <= 1'b1;
      sclReg    <= 1'b1;
      sdaReg    <= 1'b1;
      doneReg   <= 1'b0;
      ackReg    <= 1'b1;
    end else begin
      doneReg <= slotEnd;
      if (slotEnd) ackReg <= sampleBit;
      if (active) begin
        sclReg <= sclWant;
        sdaReg <= sdaWant;
      end
      if (cmd.go && !active) begin
        active <= 1'b1;
        kind   <= cmd.kind;
        shReg  <= cmd.txByte;
        bitIdx <= 4'd0;
        qIdx   <= 2'd0;
        divCnt <= '0;
      end else if (active) begin
        divCnt <= quarterEnd ? '0 : divCnt + 1'b1;
        if (quarterEnd) begin
          qIdx <= qIdx + 2'd1;
          if (qIdx == 2'd2) sampleBit <= sdaIn;
          if (qIdx == 2'd3 && kind == SLOT_BYTE && bitIdx != 4'd8) begin
            shReg  <= {shReg[6:0], sampleBit};
            bitIdx <= bitIdx + 4'd1;
          end
        end
        if (slotEnd) active <= 1'b0;
      end
    end
  end

  assign rsp.done   = doneReg;
  assign rsp.ackBit = ackReg;
  assign rsp.rxByte = shReg;
  assign rsp.active = active;
  assign curKind    = kind;
  assign sclOut     = sclReg;
  assign sdaOut     = sdaReg;

endmodule

// File: rtl/i2cmbx_ctrl.sv
module i2cmbx_ctrl
  import i2cmbx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  hostAddr,
  input  logic        hostWe,
  input  logic [15:0] hostWrData,
  output logic [15:0] hostRdData,
  output slotCmd_t    cmd,
  input  slotRsp_t    rsp,
  output logic        busy,
  output logic        rdDone,
  output logic        nackErr
);

  step_e       step;
  logic        pending;
  logic        aborted;
  logic        isWrite;
  logic [6:0]  slaveAddr;
  logic [15:0] extReg;
  logic [15:0] rdMbox;

  always_comb begin
    cmd.go     = pending && !rsp.active;
    cmd.kind   = SLOT_BYTE;
    cmd.txByte = 8'hFF;
    unique case (step)
      STP_START, STP_RSTART: cmd.kind = SLOT_START;
      STP_STOP:              cmd.kind = SLOT_STOP;
      STP_ADDRW:             cmd.txByte = {slaveAddr, 1'b0};
      STP_REG:               cmd.txByte = extReg[7:0];
      STP_DATA:              cmd.txByte = extReg[15:8];
      STP_ADDRR:             cmd.txByte = {slaveAddr, 1'b1};
      default:               cmd.txByte = 8'hFF;
    endcase
  end

  always_comb begin
    hostRdData = 16'h0000;
    unique case (hostAddr)
      REG_EXT:  hostRdData = rdMbox;
      REG_STAT: begin
        hostRdData[STAT_BUSY_BIT]  = busy;
        hostRdData[STAT_NACK_BIT]  = nackErr;
        hostRdData[STAT_RDONE_BIT] = rdDone;
      end
      default:  hostRdData = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step      <= STP_IDLE;
      pending   <= 1'b0;
      aborted   <= 1'b0;
      isWrite   <= 1'b0;
      slaveAddr <= 7'd0;
      extReg    <= 16'h0000;
      rdMbox    <= 16'h0000;
      busy      <= 1'b0;
      rdDone    <= 1'b0;
      nackErr   <= 1'b0;
    end else begin
      if (hostWe) begin
        unique case (hostAddr)
          REG_CMD: if (!busy) begin
            slaveAddr <= hostWrData[7:1];
            isWrite   <= hostWrData[CMD_WRITE_BIT];
            busy      <= 1'b1;
            aborted   <= 1'b0;
            step      <= STP_START;
            pending   <= 1'b1;
          end
          REG_EXT: if (!busy) extReg <= hostWrData;
          REG_STAT: begin
            if (hostWrData[STAT_RDONE_BIT]) rdDone  <= 1'b0;
            if (hostWrData[STAT_NACK_BIT])  nackErr <= 1'b0;
          end
          default: ;
        endcase
      end
      if (cmd.go) pending <= 1'b0;
      if (rsp.done) begin
        pending <= 1'b1;
        unique case (step)
          STP_START:  step <= STP_ADDRW;
          STP_RSTART: step <= STP_ADDRR;
          STP_ADDRW, STP_REG, STP_DATA, STP_ADDRR: begin
            if (rsp.ackBit) begin
              nackErr <= 1'b1;
              aborted <= 1'b1;
              step    <= STP_STOP;
            end else if (step == STP_ADDRW) step <= STP_REG;
            else if (step == STP_REG)       step <= isWrite ? STP_DATA : STP_RSTART;
            else if (step == STP_ADDRR)     step <= STP_RDATA;
            else                            step <= STP_STOP;
          end
          STP_RDATA: begin
            rdMbox <= {rsp.rxByte, 8'h00};
            step   <= STP_STOP;
          end
          STP_STOP: begin
            pending <= 1'b0;
            busy    <= 1'b0;
            step    <= STP_IDLE;
            if (!isWrite && !aborted) rdDone <= 1'b1;
          end
          default: pending <= 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_mailbox_master.sv
module i2c_mailbox_master
  import i2cmbx_pkg::*;
#(
  parameter int CLK_DIV = 400
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  hostAddr,
  input  logic        hostWe,
  input  logic [15:0] hostWrData,
  output logic [15:0] hostRdData,
  output logic        sclOut,
  output logic        sdaOut,
  input  logic        sdaIn
);

  slotCmd_t  slotCmd;
  slotRsp_t  slotRsp;
  slotKind_e curKind;
  logic      busy, rdDone, nackErr;

  i2cmbx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostAddr   (hostAddr),
    .hostWe     (hostWe),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .cmd        (slotCmd),
    .rsp        (slotRsp),
    .busy       (busy),
    .rdDone     (rdDone),
    .nackErr    (nackErr)
  );

  i2cmbx_bit_engine #(.CLK_DIV(CLK_DIV)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (slotCmd),
    .rsp     (slotRsp),
    .curKind (curKind),
    .sclOut  (sclOut),
    .sdaOut  (sdaOut),
    .sdaIn   (sdaIn)
  );

endmodule

// File: rtl/i2cmbx_checker.sv
module i2cmbx_checker
  import i2cmbx_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  hostAddr,
  input logic        hostWe,
  input logic [15:0] hostWrData,
  input logic        sclOut,
  input logic        sdaOut,
  input logic        busy,
  input logic        rdDone,
  input logic        nackErr,
  input slotKind_e   curKind
);

  assert_busy_by_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(hostWe && hostAddr == REG_CMD));

  assert_cmd_keeps_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostWe && hostAddr == REG_CMD) |=> busy);

  assert_rdone_with_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdDone) |-> $fell(busy));

  assert_nack_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (nackErr && !(hostWe && hostAddr == REG_STAT && hostWrData[STAT_NACK_BIT]))
      |=> nackErr);

  assert_sda_high_only_cond_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sclOut && $past(sclOut) && (sdaOut != $past(sdaOut)))
      |-> (curKind == SLOT_START || curKind == SLOT_STOP));

  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclOut && sdaOut));

endmodule

bind i2c_mailbox_master i2cmbx_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostAddr   (hostAddr),
  .hostWe     (hostWe),
  .hostWrData (hostWrData),
  .sclOut     (sclOut),
  .sdaOut     (sdaOut),
  .busy       (busy),
  .rdDone     (rdDone),
  .nackErr    (nackErr),
  .curKind    (curKind)
);

// File: tb/tb_i2c_mailbox_master.sv
`timescale 1ns/1ps
module tb_i2c_mailbox_master;

  localparam int CLK_DIV = 16;
  localparam logic [6:0] BENCH_SLV = 7'h52;
  localparam logic [8:0] EV_S = 9'h100;
  localparam logic [8:0] EV_P = 9'h101;
  localparam int NVEC = 7;
  // {isWrite, slave, register, data-or-readback, nackNonAddressBytes}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 7'h52, 8'h10, 8'hA5, 1'b0},
    {1'b0, 7'h52, 8'h03, 8'h3C, 1'b0},
    {1'b1, 7'h52, 8'hFF, 8'h00, 1'b0},
    {1'b0, 7'h52, 8'h80, 8'hC3, 1'b0},
    {1'b1, 7'h11, 8'h20, 8'h55, 1'b0},
    {1'b0, 7'h52, 8'h44, 8'h99, 1'b1},
    {1'b0, 7'h7F, 8'h01, 8'h01, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  hostAddr = 2'd2;
  logic        hostWe = 1'b0;
  logic [15:0] hostWrData = 16'h0000;
  logic [15:0] hostRdData;
  logic        sclOut, sdaOut, sdaIn;
  logic        slaveDrive = 1'b0;

  assign sdaIn = sdaOut & ~slaveDrive;

  i2c_mailbox_master #(.CLK_DIV(CLK_DIV)) dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWe(hostWe),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .sclOut(sclOut), .sdaOut(sdaOut), .sdaIn(sdaIn)
  );

  always #4 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int cycle   = 0;

  // ---------------- slave model and bus decoder ----------------
  logic [8:0] evLog [16];
  int         evCnt = 0;
  logic       prevScl = 1'b1, prevSda = 1'b1;
  logic [7:0] shByte = 8'h00;
  int         bitCnt = 0;
  logic       ackPhase = 1'b0, firstByte = 1'b0, readActive = 1'b0, pendRead = 1'b0;
  logic [7:0] rdByte = 8'h00;
  logic       nackKnob = 1'b0;
  int         lastRise = -1;
  int         minPeriod = 1000000;

  task automatic logEv(input logic [8:0] e);
    if (evCnt < 16) evLog[evCnt] = e;
    evCnt++;
  endtask

  always @(negedge clk) begin
    logic curScl, curSda;
    cycle++;
    curScl = sclOut;
    curSda = sdaOut & ~slaveDrive;
    if (rstN) begin
      if (prevScl && curScl && prevSda && !curSda) begin
        logEv(EV_S);
        bitCnt = 0; ackPhase = 0; firstByte = 1; readActive = 0; pendRead = 0;
        slaveDrive = 0;
      end else if (prevScl && curScl && !prevSda && curSda) begin
        logEv(EV_P);
      end else if (!prevScl && curScl) begin
        if (lastRise >= 0 && (cycle - lastRise) < minPeriod) minPeriod = cycle - lastRise;
        lastRise = cycle;
        if (!ackPhase && bitCnt < 8) begin
          shByte = {shByte[6:0], curSda};
          bitCnt++;
        end
      end else if (prevScl && !curScl) begin
        if (!ackPhase && bitCnt == 8) begin
          logEv({1'b0, shByte});
          ackPhase = 1;
          if (readActive) begin
            slaveDrive = 0; readActive = 0;
          end else if (firstByte) begin
            firstByte = 0;
            if (shByte[7:1] == BENCH_SLV) begin
              slaveDrive = 1; pendRead = shByte[0];
            end else slaveDrive = 0;
          end else slaveDrive = !nackKnob;
        end else if (ackPhase) begin
          ackPhase = 0; bitCnt = 0; slaveDrive = 0;
          if (pendRead) begin
            pendRead = 0; readActive = 1; slaveDrive = !rdByte[7];
          end
        end else if (readActive && bitCnt < 8) begin
          slaveDrive = !rdByte[7 - bitCnt];
        end
      end
    end
    prevScl = curScl;
    prevSda = curSda;
  end

  // ---------------- helpers ----------------
  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycle > 150000) begin
      nFails++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cycle);
      finishRun();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWe = 1'b1;
    @(negedge clk);
    hostWe = 1'b0; hostAddr = 2'd2;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] d);
    hostAddr = a;
    #1 d = hostRdData;
    hostAddr = 2'd2;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!hostRdData[12]) break;
    end
    @(negedge clk);
  endtask

  logic [8:0] expLog [16];
  int         expCnt;

  task automatic buildExp(input logic isW, input logic [6:0] slv, input logic [7:0] ra,
                          input logic [7:0] dt, input logic nk);
    expCnt = 0;
    expLog[expCnt++] = EV_S;
    expLog[expCnt++] = {1'b0, slv, 1'b0};
    if (slv == BENCH_SLV) begin
      expLog[expCnt++] = {1'b0, ra};
      if (!nk) begin
        if (isW) expLog[expCnt++] = {1'b0, dt};
        else begin
          expLog[expCnt++] = EV_S;
          expLog[expCnt++] = {1'b0, slv, 1'b1};
          expLog[expCnt++] = {1'b0, dt};
        end
      end
    end
    expLog[expCnt++] = EV_P;
  endtask

  task automatic cmpLog(input string req);
    chk({req, " event count"}, evCnt, expCnt);
    for (int i = 0; i < expCnt && i < evCnt && i < 16; i++)
      chk({req, " bus event"}, {23'd0, evLog[i]}, {23'd0, expLog[i]});
  endtask

  task automatic startTx(input logic isW, input logic [6:0] slv, input logic [7:0] ra,
                         input logic [7:0] dt, input logic nk);
    logic [15:0] st;
    rdByte = dt; nackKnob = nk;
    hostWrite(2'd2, 16'h6000);
    hostWrite(2'd1, {dt, ra});
    evCnt = 0;
    hostWrite(2'd0, {(isW ? 8'hC4 : 8'hC0), slv, 1'b0});
    readReg(2'd2, st);
    chk("R2 busy after command", {31'd0, st[12]}, 32'd1);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [15:0] st, ext;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    readReg(2'd2, st);
    chk("R1 status after reset", {16'd0, st}, 32'h0);
    readReg(2'd1, ext);
    chk("R1 readback after reset", {16'd0, ext}, 32'h0);
    chk("R1 bus idle after reset", {30'd0, sclOut, sdaOut}, 32'h3);

    for (int v = 0; v < NVEC; v++) begin
      logic isW, nk, err;
      logic [6:0] slv;
      logic [7:0] ra, dt;
      {isW, slv, ra, dt, nk} = VEC[v];
      err = (slv != BENCH_SLV) || nk;
      startTx(isW, slv, ra, dt, nk);
      waitIdle();
      buildExp(isW, slv, ra, dt, nk);
      cmpLog(err ? "R8 nack sequence" : (isW ? "R4 write sequence" : "R5 read sequence"));
      readReg(2'd2, st);
      chk("R8 error flag", {31'd0, st[13]}, {31'd0, err});
      chk("R6 read-done flag", {31'd0, st[14]}, {31'd0, (!isW && !err)});
      chk("R10 bus idle when not busy", {29'd0, st[12], sclOut, sdaOut}, 32'h3);
      if (!isW && !err) begin
        readReg(2'd1, ext);
        chk("R6 read data in upper byte", {16'd0, ext}, {16'd0, dt, 8'h00});
      end
    end

    // R8: sticky, 0 write leaves set, 1 clears
    hostWrite(2'd2, 16'h0000);
    readReg(2'd2, st);
    chk("R8 error survives zero write", {31'd0, st[13]}, 32'd1);
    hostWrite(2'd2, 16'h2000);
    readReg(2'd2, st);
    chk("R8 error cleared by one", {31'd0, st[13]}, 32'd0);

    // R7: read-done write-1-to-clear
    startTx(1'b0, BENCH_SLV, 8'h5A, 8'h81, 1'b0);
    waitIdle();
    hostWrite(2'd2, 16'h0000);
    readReg(2'd2, st);
    chk("R7 read-done survives zero write", {31'd0, st[14]}, 32'd1);
    hostWrite(2'd2, 16'h4000);
    readReg(2'd2, st);
    chk("R7 read-done cleared by one", {31'd0, st[14]}, 32'd0);

    // R3: command and mailbox writes while busy are ignored
    startTx(1'b1, BENCH_SLV, 8'h21, 8'h6B, 1'b0);
    hostWrite(2'd1, 16'hEEDD);
    hostWrite(2'd0, {8'hC0, 7'h33, 1'b0});
    waitIdle();
    buildExp(1'b1, BENCH_SLV, 8'h21, 8'h6B, 1'b0);
    cmpLog("R3 busy writes ignored");
    readReg(2'd2, st);
    chk("R3 no read started", {16'd0, st}, 32'h0);

    // R9: SCL period
    chk("R9 shortest SCL period", minPeriod, CLK_DIV);

    finishRun();
  end

endmodule